// File: doc/BRIEF.md
# Partition Bus-Lock Controller

This block keeps the legacy locked-transaction state for one switch partition. A partition has one upstream port (port 0) and `NUM_DN` downstream ports (ports 1 to `NUM_DN`). The block sees one abstracted TLP event per cycle. Each event carries its source port, target port, type, egress virtual channel and a flag that marks messages the switch generates itself. A per-port flag says whether posted requests are still queued. For every event the block returns a forward or hold decision.

A locked read from the root names a candidate downstream port. The lock is armed only when that port returns a locked completion. The controller takes that completion and releases it upstream once the port's posted requests have drained. From that point the partition is bus-locked. VC0 traffic from the other downstream ports toward the upstream port or the locked port is held until an Unlock message from the root takes effect. The Unlock also waits for the upstream posted queue to drain. While the partition is locked, the block flags traffic that a locked partition must not see. The flag is sticky and stays set until software clears it.

Top module: `part_lock_ctrl`

## Requirements
- R1: After reset, `locked`, `cpl_fwd`, `unlock_fwd` and `err_flag` are 0, `lock_port` is 0 and `tgt_hold_mask` is all zeros.
- R2: Port 0 is upstream. Event type codes are: 0 other, 1 MWr, 2 MRdLk, 3 CplLk, 4 CplDLk, 5 Unlock. An MRdLk from port 0 to a downstream port records that port as the lock candidate. While unlocked, only a CplDLk sourced by the candidate starts a lock; a CplDLk from any other port is forwarded normally.
- R3: The arming CplDLk is not signalled on `evt_fwd`. `cpl_fwd` pulses in the first cycle after it in which `posted_empty` is 1 for the candidate port. `locked` goes to 1 on the next cycle and `lock_port` shows the candidate.
- R4: While locked, a non-local event on VC0 is held (`evt_hold`=1, `evt_fwd`=0) when its source is a downstream port other than `lock_port` and its target is port 0 or `lock_port`. Events on any other VC, or aimed at other ports, are forwarded.
- R5: While locked, CplLk or CplDLk from the locked port, and MWr or MRdLk from port 0 to the locked port, are forwarded and leave `locked` at 1.
- R6: An Unlock from port 0 while locked is not signalled on `evt_fwd`. `unlock_fwd` pulses in the first cycle afterwards in which `posted_empty[0]` is 1, and `locked` drops the next cycle. Holding continues until then.
- R7: An Unlock while unlocked, or from a downstream port, changes no state. It is forwarded, or held under R4.
- R8: While locked, `err_flag` rises one cycle after any of these non-local events: a port-0 event of a type other than MWr, MRdLk or Unlock; a locked-port event other than CplLk or CplDLk; a port-0 event aimed at a downstream port other than `lock_port`.
- R9: An event with `evt_local`=1 is always forwarded and never counted as illegal.
- R10: `err_flag` stays at 1 until `err_clr` is sampled high. If an illegal event arrives in the same cycle as the clear, the flag stays at 1.
- R11: While locked, `tgt_hold_mask` has bit 0 and bit `lock_port` set. Otherwise it is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| evt_valid | input | 1 | An event is presented this cycle |
| evt_src | input | PORT_W | Port that received the TLP |
| evt_dst | input | PORT_W | Port the TLP is routed to |
| evt_type | input | 3 | TLP type code (see R2) |
| evt_vc | input | VC_W | Egress virtual channel |
| evt_local | input | 1 | Message generated inside the switch |
| posted_empty | input | NPORT | Per port: no posted requests queued |
| err_clr | input | 1 | Clears the illegal-traffic flag |
| evt_fwd | output | 1 | Event may be forwarded now |
| evt_hold | output | 1 | Event must wait for unlock |
| cpl_fwd | output | 1 | Release the arming CplDLk upstream |
| unlock_fwd | output | 1 | Release the Unlock to the locked port |
| locked | output | 1 | Partition is bus-locked |
| lock_port | output | PORT_W | Locked downstream port |
| tgt_hold_mask | output | NPORT | Ports whose VC0 ingress is held |
| err_flag | output | 1 | Sticky illegal-traffic flag |

## Verification
The assertions check on every cycle the following properties. Forward and hold never assert together. Only VC0 traffic from a non-exempt downstream port is ever held, and local messages are never held. The lock survives until an Unlock is accepted, and each release strobe is followed by the matching state change. The error flag is sticky. Only the bench's scenarios can show the full ordering: candidate selection by a prior locked read, arming gated by drain over several cycles, the rejected unlock cases, and each illegal case in turn raising the flag.

// File: rtl/plk_pkg.sv
// Shared types for the partition bus-lock controller.
// Assumes the event type code is three bits wide.
package plk_pkg;

    typedef enum logic [2:0] {
        EV_OTHER  = 3'd0,
        EV_MWR    = 3'd1,
        EV_MRDLK  = 3'd2,
        EV_CPLLK  = 3'd3,
        EV_CPLDLK = 3'd4,
        EV_UNLOCK = 3'd5
    } ev_t;

    typedef enum logic [1:0] {
        ST_IDLE    = 2'd0,
        ST_ARMING  = 2'd1,
        ST_LOCKED  = 2'd2,
        ST_RELEASE = 2'd3
    } lk_state_t;

endpackage

// File: rtl/plk_classify.sv
// Event classifier: given the current lock state, decides for a single event
// whether it is forwarded, held, consumed as a lock/unlock control, or illegal.
// Purely combinational. Assumes port 0 is the upstream port.
module plk_classify
    import plk_pkg::*;
#(
    parameter int PORT_W = 3,
    parameter int VC_W   = 3
) (
    input  logic              valid_i,
    input  logic [PORT_W-1:0] src_i,
    input  logic [PORT_W-1:0] dst_i,
    input  logic [2:0]        type_i,
    input  logic [VC_W-1:0]   vc_i,
    input  logic              local_i,
    input  lk_state_t         state_i,
    input  logic [PORT_W-1:0] lock_port_i,
    input  logic [PORT_W-1:0] cand_port_i,
    input  logic              cand_valid_i,
    output logic              fwd_o,
    output logic              hold_o,
    output logic              arm_o,
    output logic              unlock_o,
    output logic              mrdlk_o,
    output logic              illegal_o,
    output logic              locked_now_o
);

    ev_t  ev;
    logic live, from_up, from_lock, tgt_locked, blocked;
    logic up_bad_type, lock_bad_type, up_bad_tgt;

    // Decode the event against the current lock state.
    always_comb begin
        ev           = ev_t'(type_i);
        live         = valid_i && !local_i;
        locked_now_o = (state_i == ST_LOCKED) || (state_i == ST_RELEASE);
        from_up      = (src_i == '0);
        from_lock    = (src_i == lock_port_i);
        tgt_locked   = (dst_i == '0) || (dst_i == lock_port_i);

        blocked = live && locked_now_o && (vc_i == '0) && !from_up
                  && !from_lock && tgt_locked;

        arm_o    = live && (state_i == ST_IDLE) && cand_valid_i
                   && (ev == EV_CPLDLK) && (src_i == cand_port_i);
        unlock_o = live && (state_i == ST_LOCKED) && from_up && (ev == EV_UNLOCK);
        mrdlk_o  = live && (state_i == ST_IDLE) && from_up
                   && (ev == EV_MRDLK) && (dst_i != '0);

        up_bad_type   = from_up && !(ev == EV_MWR || ev == EV_MRDLK || ev == EV_UNLOCK);
        lock_bad_type = from_lock && !(ev == EV_CPLLK || ev == EV_CPLDLK);
        up_bad_tgt    = from_up && (dst_i != '0) && (dst_i != lock_port_i);
        illegal_o     = live && locked_now_o
                        && (up_bad_type || lock_bad_type || up_bad_tgt);

        hold_o = blocked;
        fwd_o  = valid_i && !blocked && !arm_o && !unlock_o;
    end

endmodule

// File: rtl/plk_state.sv
// Lock state machine: latches the candidate port from a locked read, arms on
// its locked completion, and gates both the lock and the unlock transitions
// on the relevant posted queues having drained.
module plk_state
    import plk_pkg::*;
#(
    parameter int NPORT  = 5,
    parameter int PORT_W = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              arm_i,
    input  logic              unlock_i,
    input  logic              mrdlk_i,
    input  logic [PORT_W-1:0] mrdlk_dst_i,
    input  logic [NPORT-1:0]  posted_empty_i,
    output lk_state_t         state_o,
    output logic [PORT_W-1:0] lock_port_o,
    output logic [PORT_W-1:0] cand_port_o,
    output logic              cand_valid_o,
    output logic              cpl_fwd_o,
    output logic              unlock_fwd_o
);

    lk_state_t         state_q;
    logic [PORT_W-1:0] lock_q, cand_q;
    logic              cand_v_q;
    logic              lock_drained;

    // Pick the posted-empty flag of the locked port.
    always_comb begin
        lock_drained = 1'b0;
        for (int p = 0; p < NPORT; p++) begin
            if (lock_q == PORT_W'(p)) lock_drained = posted_empty_i[p];
        end
    end

    // Release strobes fire once the matching queue is empty.
    always_comb begin
        cpl_fwd_o    = (state_q == ST_ARMING)  && lock_drained;
        unlock_fwd_o = (state_q == ST_RELEASE) && posted_empty_i[0];
    end

    // Advance the lock state and its port registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q  <= ST_IDLE;
            lock_q   <= '0;
            cand_q   <= '0;
            cand_v_q <= 1'b0;
        end else begin
            case (state_q)
                ST_IDLE: begin
                    if (mrdlk_i) begin
                        cand_q   <= mrdlk_dst_i;
                        cand_v_q <= 1'b1;
                    end
                    if (arm_i) begin
                        lock_q  <= cand_q;
                        state_q <= ST_ARMING;
                    end
                end
                ST_ARMING:  if (cpl_fwd_o) state_q <= ST_LOCKED;
                ST_LOCKED:  if (unlock_i)  state_q <= ST_RELEASE;
                ST_RELEASE: if (unlock_fwd_o) begin
                    state_q  <= ST_IDLE;
                    lock_q   <= '0;
                    cand_v_q <= 1'b0;
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end

    assign state_o      = state_q;
    assign lock_port_o  = lock_q;
    assign cand_port_o  = cand_q;
    assign cand_valid_o = cand_v_q;

    // R3: the completion strobe is followed by the locked state.
    a_r3_strobe_then_locked: assert property (@(posedge clk) disable iff (!rst_n)
        cpl_fwd_o |=> (state_q == ST_LOCKED));

    // R5: once locked, only an accepted unlock can leave the locked state.
    a_r5_lock_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_LOCKED && !unlock_i) |=> (state_q == ST_LOCKED));

    // R6: the unlock strobe returns the partition to idle.
    a_r6_unlock_then_idle: assert property (@(posedge clk) disable iff (!rst_n)
        unlock_fwd_o |=> (state_q == ST_IDLE));

    // R2: a lock is only started from idle with a recorded candidate.
    a_r2_arm_from_idle: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_ARMING && $past(state_q) == ST_IDLE) |-> $past(cand_v_q));

endmodule

// File: rtl/plk_errflag.sv
// Sticky illegal-traffic flag: set by an illegal event, cleared by a clear
// pulse; a set in the same cycle as the clear wins.
module plk_errflag (
    input  logic clk,
    input  logic rst_n,
    input  logic illegal_i,
    input  logic clr_i,
    output logic err_o
);

    logic err_q;

    // Hold the flag until it is explicitly cleared.
    always_ff @(posedge clk) begin
        if (!rst_n) err_q <= 1'b0;
        else        err_q <= (err_q && !clr_i) || illegal_i;
    end

    assign err_o = err_q;

    // R10: without a clear the flag never drops.
    a_r10_err_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (err_q && !clr_i) |=> err_q);

    // R8: the flag only rises after an illegal event.
    a_r8_err_cause: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(err_q) |-> $past(illegal_i));

endmodule

// File: rtl/part_lock_ctrl.sv
// Partition bus-lock controller top. Classifies one TLP event per cycle,
// tracks the lock state and raises a sticky flag on illegal traffic.
// Assumes port 0 is upstream and ports 1..NUM_DN are downstream.
module part_lock_ctrl
    import plk_pkg::*;
#(
    parameter  int NUM_DN = 4,
    parameter  int VC_W   = 3,
    localparam int NPORT  = NUM_DN + 1,
    localparam int PORT_W = $clog2(NPORT)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              evt_valid,
    input  logic [PORT_W-1:0] evt_src,
    input  logic [PORT_W-1:0] evt_dst,
    input  logic [2:0]        evt_type,
    input  logic [VC_W-1:0]   evt_vc,
    input  logic              evt_local,
    input  logic [NPORT-1:0]  posted_empty,
    input  logic              err_clr,
    output logic              evt_fwd,
    output logic              evt_hold,
    output logic              cpl_fwd,
    output logic              unlock_fwd,
    output logic              locked,
    output logic [PORT_W-1:0] lock_port,
    output logic [NPORT-1:0]  tgt_hold_mask,
    output logic              err_flag
);

    lk_state_t         state;
    logic [PORT_W-1:0] cand_port;
    logic              cand_valid;
    logic              arm, unlock_req, mrdlk, illegal, locked_now;

    plk_classify #(.PORT_W(PORT_W), .VC_W(VC_W)) u_classify (
        .valid_i      (evt_valid),
        .src_i        (evt_src),
        .dst_i        (evt_dst),
        .type_i       (evt_type),
        .vc_i         (evt_vc),
        .local_i      (evt_local),
        .state_i      (state),
        .lock_port_i  (lock_port),
        .cand_port_i  (cand_port),
        .cand_valid_i (cand_valid),
        .fwd_o        (evt_fwd),
        .hold_o       (evt_hold),
        .arm_o        (arm),
        .unlock_o     (unlock_req),
        .mrdlk_o      (mrdlk),
        .illegal_o    (illegal),
        .locked_now_o (locked_now)
    );

    plk_state #(.NPORT(NPORT), .PORT_W(PORT_W)) u_state (
        .clk            (clk),
        .rst_n          (rst_n),
        .arm_i          (arm),
        .unlock_i       (unlock_req),
        .mrdlk_i        (mrdlk),
        .mrdlk_dst_i    (evt_dst),
        .posted_empty_i (posted_empty),
        .state_o        (state),
        .lock_port_o    (lock_port),
        .cand_port_o    (cand_port),
        .cand_valid_o   (cand_valid),
        .cpl_fwd_o      (cpl_fwd),
        .unlock_fwd_o   (unlock_fwd)
    );

    plk_errflag u_err (
        .clk       (clk),
        .rst_n     (rst_n),
        .illegal_i (illegal),
        .clr_i     (err_clr),
        .err_o     (err_flag)
    );

    assign locked = locked_now;

    // Mark the ports whose VC0 ingress from other ports is held.
    for (genvar p = 0; p < NPORT; p++) begin : g_mask
        if (p == 0) begin : g_up
            assign tgt_hold_mask[p] = locked_now;
        end else begin : g_dn
            assign tgt_hold_mask[p] = locked_now && (lock_port == PORT_W'(p));
        end
    end

    // R4: forward and hold are never both asserted.
    a_r4_fwd_hold_excl: assert property (@(posedge clk) disable iff (!rst_n)
        !(evt_fwd && evt_hold));

    // R4: only VC0 traffic from a downstream port is ever held.
    a_r4_hold_vc0_only: assert property (@(posedge clk) disable iff (!rst_n)
        evt_hold |-> (evt_vc == '0 && evt_src != '0 && locked));

    // R9: locally generated messages always go out.
    a_r9_local_passes: assert property (@(posedge clk) disable iff (!rst_n)
        (evt_valid && evt_local) |-> evt_fwd);

    // R11: at most the upstream and one downstream port are marked.
    a_r11_mask_width: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(tgt_hold_mask) <= 2);

endmodule

// File: tb/test_part_lock_ctrl.sv
// Self-checking bench: walks a vector table through lock, hold, unlock and
// illegal-traffic scenarios, then runs directed reset and mask tests.
module test_part_lock_ctrl;

    localparam int CLK_P  = 10;
    localparam int NUM_DN = 4;
    localparam int NPORT  = NUM_DN + 1;
    localparam int PORT_W = $clog2(NPORT);
    localparam int VC_W   = 3;

    typedef struct packed {
        logic       v;
        logic [2:0] s, d, t, c;
        logic       l;
        logic [4:0] pe;
        logic       cl;
        logic       ef, eh, ec, eu, el, ee;
        logic [3:0] rq;
    } vec_t;

    function automatic vec_t mk(int v, int s, int d, int t, int c, int l, int pe,
                                int cl, int ef, int eh, int ec, int eu, int el,
                                int ee, int rq);
        vec_t x;
        x.v = 1'(v);  x.s = 3'(s);  x.d = 3'(d);  x.t = 3'(t);  x.c = 3'(c);
        x.l = 1'(l);  x.pe = 5'(pe); x.cl = 1'(cl);
        x.ef = 1'(ef); x.eh = 1'(eh); x.ec = 1'(ec); x.eu = 1'(eu);
        x.el = 1'(el); x.ee = 1'(ee); x.rq = 4'(rq);
        return x;
    endfunction

    localparam int NV = 33;
    // v  s  d  t  c  l  pe    cl | fwd hold cpl unl lock err | req
    localparam vec_t TBL [NV] = '{
        mk(1, 2, 0, 1, 0, 0, 'h1f, 0, 1, 0, 0, 0, 0, 0, 2),  // R2 idle traffic
        mk(1, 0, 3, 2, 0, 0, 'h1f, 0, 1, 0, 0, 0, 0, 0, 2),  // R2 candidate 3
        mk(1, 1, 0, 4, 0, 0, 'h1f, 0, 1, 0, 0, 0, 0, 0, 2),  // R2 non-candidate CplDLk
        mk(1, 3, 0, 4, 0, 0, 'h17, 0, 0, 0, 0, 0, 0, 0, 3),  // R3 arm, not drained
        mk(0, 0, 0, 0, 0, 0, 'h17, 0, 0, 0, 0, 0, 0, 0, 3),  // R3 still waiting
        mk(0, 0, 0, 0, 0, 0, 'h1f, 0, 0, 0, 1, 0, 1, 0, 3),  // R3 drained, strobe
        mk(1, 2, 0, 1, 0, 0, 'h1f, 0, 0, 1, 0, 0, 1, 0, 4),  // R4 held
        mk(1, 2, 3, 1, 1, 0, 'h1f, 0, 1, 0, 0, 0, 1, 0, 4),  // R4 VC1 passes
        mk(1, 2, 1, 1, 0, 0, 'h1f, 0, 1, 0, 0, 0, 1, 0, 4),  // R4 unlocked target
        mk(1, 3, 0, 3, 0, 0, 'h1f, 0, 1, 0, 0, 0, 1, 0, 5),  // R5 CplLk
        mk(1, 3, 0, 4, 0, 0, 'h1f, 0, 1, 0, 0, 0, 1, 0, 5),  // R5 CplDLk again
        mk(1, 0, 3, 1, 0, 0, 'h1f, 0, 1, 0, 0, 0, 1, 0, 5),  // R5 MWr
        mk(1, 0, 3, 2, 0, 0, 'h1f, 0, 1, 0, 0, 0, 1, 0, 5),  // R5 MRdLk
        mk(1, 1, 0, 0, 0, 1, 'h1f, 0, 1, 0, 0, 0, 1, 0, 9),  // R9 local from other port
        mk(1, 3, 0, 0, 0, 1, 'h1f, 0, 1, 0, 0, 0, 1, 0, 9),  // R9 local from locked port
        mk(1, 1, 0, 5, 0, 0, 'h1f, 0, 0, 1, 0, 0, 1, 0, 7),  // R7 unlock from downstream
        mk(1, 0, 3, 5, 0, 0, 'h1e, 0, 0, 0, 0, 0, 1, 0, 6),  // R6 unlock, not drained
        mk(1, 2, 0, 1, 0, 0, 'h1e, 0, 0, 1, 0, 0, 1, 0, 6),  // R6 still holding
        mk(0, 0, 0, 0, 0, 0, 'h1f, 0, 0, 0, 0, 1, 0, 0, 6),  // R6 drained, strobe
        mk(1, 2, 0, 1, 0, 0, 'h1f, 0, 1, 0, 0, 0, 0, 0, 6),  // R6 released
        mk(1, 0, 3, 5, 0, 0, 'h1f, 0, 1, 0, 0, 0, 0, 0, 7),  // R7 unlock while idle
        mk(1, 0, 2, 2, 0, 0, 'h1f, 0, 1, 0, 0, 0, 0, 0, 2),  // R2 candidate 2
        mk(1, 2, 0, 4, 0, 0, 'h1f, 0, 0, 0, 0, 0, 0, 0, 3),  // R3 arm
        mk(0, 0, 0, 0, 0, 0, 'h1f, 0, 0, 0, 1, 0, 1, 0, 3),  // R3 strobe
        mk(1, 0, 2, 0, 0, 0, 'h1f, 0, 1, 0, 0, 0, 1, 1, 8),  // R8 bad upstream type
        mk(0, 0, 0, 0, 0, 0, 'h1f, 1, 0, 0, 0, 0, 1, 0, 10), // R10 clear
        mk(1, 2, 0, 1, 0, 0, 'h1f, 0, 1, 0, 0, 0, 1, 1, 8),  // R8 MWr from locked port
        mk(0, 0, 0, 0, 0, 0, 'h1f, 1, 0, 0, 0, 0, 1, 0, 10), // R10 clear
        mk(1, 0, 4, 1, 0, 0, 'h1f, 0, 1, 0, 0, 0, 1, 1, 8),  // R8 target unlocked port
        mk(1, 0, 4, 1, 0, 0, 'h1f, 1, 1, 0, 0, 0, 1, 1, 10), // R10 set beats clear
        mk(0, 0, 0, 0, 0, 0, 'h1f, 1, 0, 0, 0, 0, 1, 0, 10), // R10 clear
        mk(1, 0, 2, 5, 0, 0, 'h1f, 0, 0, 0, 0, 0, 1, 0, 6),  // R6 unlock
        mk(0, 0, 0, 0, 0, 0, 'h1f, 0, 0, 0, 0, 1, 0, 0, 6)   // R6 strobe
    };

    logic              clk = 1'b0;
    logic              rst_n;
    logic              evt_valid, evt_local, err_clr;
    logic [PORT_W-1:0] evt_src, evt_dst;
    logic [2:0]        evt_type;
    logic [VC_W-1:0]   evt_vc;
    logic [NPORT-1:0]  posted_empty;
    logic              evt_fwd, evt_hold, cpl_fwd, unlock_fwd, locked, err_flag;
    logic [PORT_W-1:0] lock_port;
    logic [NPORT-1:0]  tgt_hold_mask;

    int  n_chk  = 0;
    int  n_fail = 0;
    bit  done   = 1'b0;

    always #(CLK_P / 2) clk = ~clk;

    part_lock_ctrl #(.NUM_DN(NUM_DN), .VC_W(VC_W)) i_part_lock_ctrl (
        .clk           (clk),
        .rst_n         (rst_n),
        .evt_valid     (evt_valid),
        .evt_src       (evt_src),
        .evt_dst       (evt_dst),
        .evt_type      (evt_type),
        .evt_vc        (evt_vc),
        .evt_local     (evt_local),
        .posted_empty  (posted_empty),
        .err_clr       (err_clr),
        .evt_fwd       (evt_fwd),
        .evt_hold      (evt_hold),
        .cpl_fwd       (cpl_fwd),
        .unlock_fwd    (unlock_fwd),
        .locked        (locked),
        .lock_port     (lock_port),
        .tgt_hold_mask (tgt_hold_mask),
        .err_flag      (err_flag)
    );

    task automatic chk(string what, int req, logic [7:0] act, logic [7:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL R%0d %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic drive(int v, int s, int d, int t, int c, int l, int pe, int cl);
        evt_valid    = 1'(v);
        evt_src      = PORT_W'(s);
        evt_dst      = PORT_W'(d);
        evt_type     = 3'(t);
        evt_vc       = VC_W'(c);
        evt_local    = 1'(l);
        posted_empty = NPORT'(pe);
        err_clr      = 1'(cl);
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    endtask

    // Watchdog: a hung run counts as one failed check.
    initial begin
        #(CLK_P * 100000);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        drive(0, 0, 0, 0, 0, 0, 'h1f, 0);
        rst_n = 1'b0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        #1;
        // R1: reset state
        chk("reset locked", 1, 8'(locked), 8'd0);
        chk("reset lock_port", 1, 8'(lock_port), 8'd0);
        chk("reset err", 1, 8'(err_flag), 8'd0);
        chk("reset mask", 1, 8'(tgt_hold_mask), 8'd0);
        chk("reset strobes", 1, 8'({cpl_fwd, unlock_fwd}), 8'd0);

        for (int i = 0; i < NV; i++) begin
            @(negedge clk);
            drive(TBL[i].v, TBL[i].s, TBL[i].d, TBL[i].t, TBL[i].c, TBL[i].l,
                  TBL[i].pe, TBL[i].cl);
            #1;
            chk($sformatf("vec%0d fwd", i), TBL[i].rq, 8'(evt_fwd), 8'(TBL[i].ef));
            chk($sformatf("vec%0d hold", i), TBL[i].rq, 8'(evt_hold), 8'(TBL[i].eh));
            chk($sformatf("vec%0d cpl_fwd", i), TBL[i].rq, 8'(cpl_fwd), 8'(TBL[i].ec));
            chk($sformatf("vec%0d unlock_fwd", i), TBL[i].rq, 8'(unlock_fwd), 8'(TBL[i].eu));
            @(posedge clk);
            #1;
            chk($sformatf("vec%0d locked", i), TBL[i].rq, 8'(locked), 8'(TBL[i].el));
            chk($sformatf("vec%0d err", i), TBL[i].rq, 8'(err_flag), 8'(TBL[i].ee));
        end

        // R11 and R3: lock on port 4, then check the port and mask.
        @(negedge clk); drive(1, 0, 4, 2, 0, 0, 'h1f, 0);
        @(negedge clk); drive(1, 4, 0, 4, 0, 0, 'h1f, 0);
        @(negedge clk); drive(0, 0, 0, 0, 0, 0, 'h1f, 0);
        @(negedge clk); #1;
        chk("lock on port 4", 3, 8'(locked), 8'd1);
        chk("lock_port", 3, 8'(lock_port), 8'd4);
        chk("hold mask", 11, 8'(tgt_hold_mask), 8'h11);

        // R1: reset while locked returns everything to idle.
        rst_n = 1'b0;
        @(posedge clk); #1;
        chk("reset mid-lock locked", 1, 8'(locked), 8'd0);
        chk("reset mid-lock port", 1, 8'(lock_port), 8'd0);
        chk("reset mid-lock mask", 11, 8'(tgt_hold_mask), 8'd0);
        @(negedge clk); rst_n = 1'b1;

        // R2: after reset no candidate exists, so a CplDLk cannot arm.
        drive(1, 4, 0, 4, 0, 0, 'h1f, 0);
        #1;
        chk("no candidate fwd", 2, 8'(evt_fwd), 8'd1);
        @(negedge clk); drive(0, 0, 0, 0, 0, 0, 'h1f, 0);
        #1;
        chk("no candidate cpl_fwd", 2, 8'(cpl_fwd), 8'd0);
        @(posedge clk); #1;
        chk("no candidate locked", 2, 8'(locked), 8'd0);

        repeat (2) @(negedge clk);
        finish_run();
    end

endmodule